// File: doc/BRIEF.md
# LFSR-Driven Checksum Test Harness

This block wraps a circuit under test so that a timing failure inside it can be seen on chip without streaming vectors off the device. After a start pulse, a pseudo-random generator feeds a new stimulus word to the circuit under test every cycle. Each registered result is folded into an XOR accumulator.

After a configured number of results has been folded, the accumulator is copied into a checksum register and a done flag is raised. A host runs the harness once at a safe operating point to obtain a golden checksum. It then repeats the run under stressed conditions and compares the two. Any single wrong result changes the checksum.

The circuit under test here is a small registered function, `x + rotl(x,3)`. A perturbation port is XORed onto its result. This port models a failing path or an injected fault. It is held at zero in normal use.

Top module: `lfsr_checksum_harness`

## Requirements
- R1: While reset is low, `done` is 0, `checksum` is 0 and `stim` equals the seed (default 16'hACE1).
- R2: A start pulse sampled at a clock edge loads the generator with the seed and the accumulator with its initial value (default 16'h5A5A), and clears the iteration count. From that edge on, `stim` shows the seed and `done` is 0.
- R3: While issuing, the generator steps once per cycle as a right-shifting Galois register: next = (x >> 1) XOR (x[0] ? 16'hB400 : 0). This is maximal length and never reaches zero.
- R4: The circuit under test registers `(x + rotl(x,3)) XOR fault_mask` at the edge where the generator value `x` is issued. `fault_mask` is sampled at that same edge.
- R5: The accumulator XORs in every result of the circuit under test exactly once, one cycle after that result is registered.
- R6: After ITERS results have been folded, the final accumulator value is loaded into `checksum` and `done` rises. This happens at the (ITERS+1)th edge after the start edge.
- R7: Once `done` is high, `done` and `checksum` hold until the next start. `fault_mask` has no effect while the harness is idle.
- R8: A start during a run abandons that run, and a complete fresh run begins from the seed.
- R9: Identical runs give identical checksums. A single corrupted result with mask m gives exactly golden XOR m, which differs from golden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous run start / restart |
| fault_mask | input | W | XOR perturbation applied to the circuit-under-test result |
| stim | output | W | Current generator value driven into the circuit under test |
| checksum | output | W | Latched checksum of the last completed run |
| done | output | 1 | High from run completion until the next start |

## Verification
The hardest situation to reach from the ports is a corruption that lands on exactly one result. The mask is asserted for a single clock, placed after a setup time of two nanoseconds following an edge. As a result, exactly one issuing edge samples it.

The bench also restarts a run midway through. It then confirms that the checksum of the restarted run still equals the golden value. This shows that no partial accumulation survives the restart.

// File: rtl/lfsr_checksum_harness.sv
module lfsr_checksum_harness #(
  parameter int W = 16,
  parameter int ITERS = 2**28,
  parameter logic [W-1:0] TAPS = 'hB400,
  parameter logic [W-1:0] SEED = 'hACE1,
  parameter logic [W-1:0] ACC_INIT = 'h5A5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] fault_mask,
  output logic [W-1:0] stim,
  output logic [W-1:0] checksum,
  output logic         done
);
  localparam int CW = $clog2(ITERS + 1);
  localparam logic [CW-1:0] LIM = CW'(ITERS);

  logic [W-1:0]  lfsr, cut_q, acc, sum;
  logic [CW-1:0] cnt;
  logic          busy, cut_v, done_q;

  wire           issuing = busy && (cnt != LIM);
  wire [W-1:0]   lfsr_nx = (lfsr >> 1) ^ (lfsr[0] ? TAPS : '0);
  wire [W-1:0]   cut_d   = (lfsr + {lfsr[W-4:0], lfsr[W-1:W-3]}) ^ fault_mask;
  wire [W-1:0]   acc_nx  = acc ^ cut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr   <= SEED;
      acc    <= ACC_INIT;
      cut_q  <= '0;
      sum    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      cut_v  <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      lfsr   <= SEED;
      acc    <= ACC_INIT;
      cnt    <= '0;
      busy   <= 1'b1;
      cut_v  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cut_v <= issuing;
      if (issuing) begin
        lfsr  <= lfsr_nx;
        cut_q <= cut_d;
        cnt   <= cnt + 1'b1;
      end
      if (cut_v) begin
        acc <= acc_nx;
        if (!issuing) begin
          sum    <= acc_nx;
          done_q <= 1'b1;
          busy   <= 1'b0;
        end
      end
    end
  end

  assign stim     = lfsr;
  assign checksum = sum;
  assign done     = done_q;

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (stim == SEED) && !done);

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0) && busy && !cut_v);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && !cut_v && (cnt == LIM));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(checksum));
endmodule

// File: tb/test_lfsr_checksum_harness.sv
module test_lfsr_checksum_harness;
  localparam int W = 16;
  localparam int N = 50;
  localparam logic [W-1:0] SEED = 16'hACE1;
  localparam logic [W-1:0] AINIT = 16'h5A5A;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] fault_mask = '0;
  logic [W-1:0] stim, checksum;
  logic done;

  int tot_n = 0, pass_n = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lfsr_checksum_harness #(.W(W), .ITERS(N)) i_lfsr_checksum_harness (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_mask(fault_mask),
    .stim(stim), .checksum(checksum), .done(done));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tot_n++;
    if (ok) pass_n++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  // behavioural reference model
  logic [W-1:0] m_gen, m_acc, m_sum;
  logic [W-1:0] pend[$];
  int m_issued;
  bit m_busy, m_done;

  function automatic logic [W-1:0] gen_step(input logic [W-1:0] x);
    logic [W-1:0] y = x >> 1;
    if (x[0]) y = y ^ 16'hB400;
    return y;
  endfunction

  function automatic logic [W-1:0] cut_fn(input logic [W-1:0] x);
    logic [W-1:0] r = (x << 3) | (x >> (W - 3));
    return x + r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gen = SEED; m_acc = AINIT; m_sum = '0; pend.delete();
      m_issued = 0; m_busy = 0; m_done = 0;
    end else if (start) begin
      m_gen = SEED; m_acc = AINIT; pend.delete();
      m_issued = 0; m_busy = 1; m_done = 0;
    end else if (m_busy) begin
      bit popped = 0;
      if (pend.size() > 0) begin
        m_acc = m_acc ^ pend.pop_front();
        popped = 1;
      end
      if (m_issued < N) begin
        pend.push_back(cut_fn(m_gen) ^ fault_mask);
        m_gen = gen_step(m_gen);
        m_issued++;
      end else if (popped && pend.size() == 0) begin
        m_sum = m_acc; m_done = 1; m_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(stim == m_gen, "R3", "stim vs model", stim, m_gen);
      check(done == m_done, "R6", "done vs model", done, m_done);
      check(checksum == m_sum, "R5", "checksum vs model", checksum, m_sum);
    end
  end

  task automatic run(input int inj_at, input logic [W-1:0] inj_mask,
                     input int restart_at, output int lat);
    int guard = 0;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    @(negedge clk);
    check(stim == SEED && done == 1'b0, "R2", "seed loaded after start",
          {stim, 15'b0, done}, {SEED, 16'b0});
    lat = 0;
    forever begin
      @(posedge clk); lat++; guard++;
      #2;
      fault_mask = (lat == inj_at) ? inj_mask : '0;
      if (lat == restart_at && start == 1'b0 && guard < 2 * N) begin
        start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        lat = 0;
        restart_at = -1;
      end
      @(negedge clk);
      if (done || guard > 4 * N) break;
    end
    fault_mask = '0;
  endtask

  initial begin
    logic [W-1:0] golden;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(checksum == '0, "R1", "checksum in reset", checksum, 0);
    check(stim == SEED, "R1", "stim in reset", stim, SEED);
    @(posedge clk); #2 rst_n = 1'b1; fault_mask = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7 mask ignored while idle before any run
    check(checksum == '0 && done == 1'b0, "R7", "idle mask no effect",
          {checksum, 15'b0, done}, 0);
    check(stim == SEED, "R7", "idle stim frozen", stim, SEED);
    #1 fault_mask = '0;

    run(-1, '0, -1, lat);
    check(lat == N + 1, "R6", "done latency", lat, N + 1);
    check(checksum == m_sum && done, "R9", "golden run", checksum, m_sum);
    golden = checksum;

    @(posedge clk); #2 fault_mask = 16'h1234;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(done == 1'b1, "R7", "done holds", done, 1);
    check(checksum == golden, "R7", "checksum holds under idle mask",
          checksum, golden);
    #1 fault_mask = '0;

    run(-1, '0, -1, lat);
    check(checksum == golden, "R9", "repeat run matches golden",
          checksum, golden);

    // R4 single corrupted result shifts checksum by exactly the mask
    run(10, 16'h0400, -1, lat);
    check(checksum == (golden ^ 16'h0400), "R4", "corrupted checksum",
          checksum, golden ^ 16'h0400);
    check(checksum != golden, "R9", "corruption detected", checksum, golden);

    run(-1, '0, 20, lat);
    check(lat == N + 1, "R8", "restart latency", lat, N + 1);
    check(checksum == golden, "R8", "restart matches golden",
          checksum, golden);

    finished = 1;
    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tot_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_n, tot_n);
      $finish;
    end
  end
endmodule